// File: doc/BRIEF.md
# Quad PLL Reset and Lock Status Register

This block is one 32-bit control and status word for a group of up to four transceiver PLLs. Each PLL gets a 4-bit slice of the word. The slice holds a reset bit that software drives, the live lock state of that PLL, and two error flags that stay set once an event occurs. Software writes the word to hold PLLs in reset or release them. It reads the word back to see whether each PLL has locked and whether it has lost lock or lost its reference clock since the flags were last cleared.

The lock and clock-lost inputs from the PLLs can be asynchronous to the register clock. Each passes through a two-stage synchronizer before any logic uses it. A separate bit in the upper half of the word is a write-only clear command: writing it with 1 clears every error flag at once, and the bit is not stored. The register port is a plain write enable with data, plus a read data bus that always shows the current contents. There is no stream traffic, so there is no back-pressure.

Top module: `pll_ctl_stat_reg`

## Requirements
- R1: PLL n uses read bits 4n+3..4n. Within that slice, bit 0 is the reset state, bit 1 is the synchronized lock state, bit 2 is the lost-lock flag and bit 3 is the clock-lost flag.
- R2: While `rst_n` is low, and after it is released, every PLL reset bit is 1 and every flag is 0. With all inputs low and four PLLs, the word reads 0x0000_1111 and `pll_rst_out` is all ones.
- R3: A write copies `wr_data` bit 4n into the reset bit of PLL n. That value drives `pll_rst_out[n]` and reads back from the next clock edge. Writing 0x1111 holds all four PLLs in reset. Writing 0x1110 afterwards releases only PLL 0.
- R4: The lock bit follows `lock_in[n]` through a two-flop synchronizer. It still shows the old value after the first rising edge following a change, and shows the new value after the second.
- R5: The lost-lock flag is set one edge after the synchronized lock falls from 1 to 0. It stays set when lock returns.
- R6: The clock-lost flag is set one edge after the synchronized `refclk_lost_in[n]` is seen high, even for a single-cycle pulse. It stays set when the input returns low.
- R7: A write with bit 16 set clears both flags of every PLL. Bit 16 always reads as 0.
- R8: If a flag-setting event occurs in the same cycle as a clear, the flag stays set.
- R9: Bits 31..17 always read 0, and so do the slices of PLLs beyond `N_PLL`.
- R10: A PLL that is out of reset, locked and has no flags set reads as slice value 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data: reset bits at 4n, clear command at bit 16 |
| rd_data | output | 32 | Current register contents |
| lock_in | input | N_PLL | Lock indication from each PLL, asynchronous |
| refclk_lost_in | input | N_PLL | Reference-clock-lost indication per PLL, asynchronous |
| pll_rst_out | output | N_PLL | Reset to each PLL, active high |

## Verification
The main instance is built with the default of four PLLs. This makes every slice of the lower half-word live, so the all-reset pattern 0x1111 and the release of a single PLL can be checked exactly. A second instance with three PLLs runs on the same stimulus. It brings the zero readback of an absent PLL slice within reach. Driving the clock-lost input high while a clear is written exercises the case where an event and a clear meet in the same cycle.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int unsigned MAX_PLL   = 4;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned CLR_BIT   = 16;
  // positions inside one PLL slice
  localparam int unsigned F_RST     = 0;
  localparam int unsigned F_LOCK    = 1;
  localparam int unsigned F_LOSTLK  = 2;
  localparam int unsigned F_CLKLOST = 3;

  typedef struct packed {
    logic clk_lost;
    logic lost_lock;
    logic lock;
    logic rst;
  } pll_slice_t;
endpackage

// File: rtl/pll_bit_sync.sv
module pll_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pll_slice.sv
module pll_slice
  import pll_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_raw,
  input  logic       clklost_raw,
  input  logic       rst_we,
  input  logic       rst_wval,
  input  logic       flag_clr,
  output pll_slice_t slice,
  output logic       pll_rst
);
  logic lock_s, clklost_s, lock_prev;
  logic rst_q, lost_q, ckl_q;
  logic lock_fall;

  pll_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
    .clk(clk), .rst_n(rst_n), .d_async(lock_raw), .q_sync(lock_s));
  pll_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_ckl (
    .clk(clk), .rst_n(rst_n), .d_async(clklost_raw), .q_sync(clklost_s));

  assign lock_fall = lock_prev & ~lock_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q     <= 1'b1;
      lock_prev <= 1'b0;
      lost_q    <= 1'b0;
      ckl_q     <= 1'b0;
    end else begin
      lock_prev <= lock_s;
      if (rst_we) rst_q <= rst_wval;
      // a new event overrides a clear in the same cycle
      if (lock_fall)     lost_q <= 1'b1;
      else if (flag_clr) lost_q <= 1'b0;
      if (clklost_s)     ckl_q  <= 1'b1;
      else if (flag_clr) ckl_q  <= 1'b0;
    end
  end

  assign slice = '{clk_lost: ckl_q, lost_lock: lost_q, lock: lock_s, rst: rst_q};
  assign pll_rst = rst_q;

  a_r3_reset_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    rst_we |=> (pll_rst == $past(rst_wval)));
  a_r3_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_we |=> $stable(pll_rst));
  a_r5_fall_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_s) |=> slice.lost_lock);
  a_r6_lost_clk_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clklost_s |=> slice.clk_lost);
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (slice.clk_lost && !flag_clr) |=> slice.clk_lost);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !clklost_s) |=> !slice.clk_lost);
  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && clklost_s) |=> slice.clk_lost);
endmodule

// File: rtl/pll_ctl_stat_reg.sv
module pll_ctl_stat_reg
  import pll_ctl_pkg::*;
#(
  parameter int unsigned N_PLL       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [N_PLL-1:0] lock_in,
  input  logic [N_PLL-1:0] refclk_lost_in,
  output logic [N_PLL-1:0] pll_rst_out
);
  localparam int unsigned LIVE_W = MAX_PLL * NIB_W;

  logic             flag_clr;
  logic [LIVE_W-1:0] live_bits;
  logic             unused_wr;

  assign flag_clr  = wr_en & wr_data[CLR_BIT];
  assign unused_wr = ^wr_data;

  for (genvar g = 0; g < MAX_PLL; g++) begin : g_slot
    if (g < N_PLL) begin : g_live
      pll_slice_t sl;
      pll_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_raw   (lock_in[g]),
        .clklost_raw(refclk_lost_in[g]),
        .rst_we     (wr_en),
        .rst_wval   (wr_data[g*NIB_W + F_RST]),
        .flag_clr   (flag_clr),
        .slice      (sl),
        .pll_rst    (pll_rst_out[g])
      );
      assign live_bits[g*NIB_W +: NIB_W] = sl;
    end else begin : g_absent
      assign live_bits[g*NIB_W +: NIB_W] = '0;
    end
  end

  assign rd_data = {{(REG_W-LIVE_W){1'b0}}, live_bits};

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:16] == 16'h0);
  a_r1_reset_bits_match_pins: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] == pll_rst_out[0]);
endmodule

// File: tb/pll_ctl_stat_reg_tb.sv
`timescale 1ns/1ps
module pll_ctl_stat_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  lock_in = '0;
  logic [3:0]  ckl_in = '0;
  logic [31:0] rd_data, rd_small;
  logic [3:0]  rst_out;
  logic [2:0]  rst_small;
  int vectors = 0;
  int errors  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_ctl_stat_reg #(.N_PLL(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .lock_in(lock_in), .refclk_lost_in(ckl_in),
    .pll_rst_out(rst_out));

  pll_ctl_stat_reg #(.N_PLL(3)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_small), .lock_in(lock_in[2:0]), .refclk_lost_in(ckl_in[2:0]),
    .pll_rst_out(rst_small));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    cyc(3); rst_n = 1'b1; cyc(2);
    chk("R2 word", rd_data, 32'h0000_1111);
    chk("R2 pins", {28'h0, rst_out}, 32'hF);
  endtask

  task automatic t_release;
    wr(32'h0000_1111);
    chk("R3 all held", rd_data, 32'h1111);
    wr(32'h0000_1110);
    chk("R3 only pll0 word", rd_data, 32'h1110);
    chk("R3 only pll0 pins", {28'h0, rst_out}, 32'hE);
    wr(32'h0000_0000);
    chk("R1 released", rd_data, 32'h0);
  endtask

  task automatic t_lock;
    @(negedge clk); lock_in = 4'hF;
    @(negedge clk);
    chk("R4 one edge", rd_data, 32'h0);
    @(negedge clk);
    chk("R4 two edges", rd_data, 32'h2222);
    chk("R10 healthy", {28'h0, rd_data[3:0]}, 32'h2);
  endtask

  task automatic t_lost_lock;
    @(negedge clk); lock_in[1] = 1'b0;
    cyc(3);
    chk("R5 flag set", rd_data, 32'h2242);
    lock_in[1] = 1'b1;
    cyc(3);
    chk("R5 flag holds", rd_data, 32'h2262);
  endtask

  task automatic t_clear;
    wr(32'h0001_0000);
    chk("R7 cleared", rd_data, 32'h2222);
    chk("R7 bit16 zero", {31'h0, rd_data[16]}, 32'h0);
  endtask

  task automatic t_refclk;
    @(negedge clk); ckl_in[2] = 1'b1;
    @(negedge clk); ckl_in[2] = 1'b0;
    cyc(3);
    chk("R6 pulse captured", rd_data, 32'h2A22);
    cyc(4);
    chk("R6 flag holds", rd_data, 32'h2A22);
  endtask

  task automatic t_conflict;
    @(negedge clk); ckl_in[3] = 1'b1;
    cyc(4);
    wr(32'h0001_0000);
    chk("R8 event wins", rd_data, 32'hA222);
    ckl_in[3] = 1'b0;
    cyc(3);
    wr(32'h0001_0000);
    chk("R7 clear after event", rd_data, 32'h2222);
  endtask

  task automatic t_upper;
    wr(32'hFFFF_FFFF);
    chk("R9 upper zero", rd_data, 32'h0000_3333);
    chk("R9 absent slice", rd_small, 32'h0000_0333);
    chk("R3 small pins", {29'h0, rst_small}, 32'h7);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_release;
    t_lock;
    t_lost_lock;
    t_clear;
    t_refclk;
    t_conflict;
    t_upper;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule